// File: doc/BRIEF.md
# Servo Profile and Hold-off Controller

This block keeps the configuration for a multi-channel servo loop. Every channel owns a bank of profiles. Each profile holds the tuning values for its channel: a 32-bit frequency word, a 16-bit phase word, a signed 17-bit setpoint offset, an input selector, a hold-off count and three 18-bit filter coefficients. Each channel also has a small control register. It holds an RF output enable, a filter-update enable and the number of the active profile. All storage is loaded through one write-only address/data bus.

The servo datapath steps through the channels. For each one it puts the channel number on a lookup port and receives that channel's active profile, already split into its fields. Each channel's RF switch output follows its output enable on the clock edge that stores the control write. Filter updates are gated. When any field of a channel's control register changes, a per-channel counter is loaded with the hold-off count of the newly selected profile. The counter then drops by one on each servo-cycle tick. A channel may update only when both of its enables are set and its counter has reached zero.

Top module: `servo_profile_ctl`

## Requirements
- R1: A bus write with address bit 11 clear stores the 18-bit data at profile word (channel << 8) | (profile << 3) | word, with channel in bits 10:8, profile in bits 7:3 and word index in bits 2:0.
- R2: The lookup port returns the fields of the active profile of channel `lk_ch`. Frequency bits 31:16 come from word 0 and bits 15:0 from word 6. Phase comes from word 2 bits 15:0. Input select comes from word 3 bits 2:0. Offset comes from word 4 bits 16:0. b1 is word 1, a1 is word 5 and b0 is word 7.
- R3: A write to address 0x800 | channel (bit 3 clear) sets that channel's control: bit 0 output enable, bit 1 update enable, bits 6:2 profile. `rf_on` for that channel equals bit 0 from the clock edge that stores the write.
- R4: A control write whose value equals the current control value leaves the hold-off counter untouched.
- R5: `upd_ok` of a channel is high exactly when its output enable and update enable are both set and its hold-off counter is zero.
- R6: A control write that changes any field loads the counter from word 3 bits 17:8 of the newly selected profile. With a count of N, `upd_ok` stays low until N ticks have passed. With N of 0, `upd_ok` rises at once.
- R7: The counter drops by one on each `cyc_tick` and stays at zero once it gets there.
- R8: A write to address 0x808 stores data bit 0 as the global run flag `run_on`. The flag holds its value between such writes.
- R9: After reset all control registers, counters and `run_on` are zero, so `rf_on` and `upd_ok` are all low.
- R10: A control write to one channel does not change the state or outputs of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 12 | Bus word address |
| wr_data | input | 18 | Bus write data |
| cyc_tick | input | 1 | One pulse per servo cycle |
| lk_ch | input | 3 | Channel selected for lookup |
| lk_prof | output | 5 | Active profile of the looked-up channel |
| lk_ftw | output | 32 | Frequency word |
| lk_pow | output | 16 | Phase word |
| lk_offs | output | 17 | Setpoint offset |
| lk_adc | output | 3 | Input selector |
| lk_a1 | output | 18 | Feedback coefficient |
| lk_b0 | output | 18 | Current-input coefficient |
| lk_b1 | output | 18 | Previous-input coefficient |
| rf_on | output | 8 | Per-channel RF switch |
| upd_ok | output | 8 | Per-channel update permit |
| run_on | output | 1 | Global run flag |

## Verification
A counter that is loaded from the wrong profile, or that misses a tick, shows up as `upd_ok` rising one or more ticks early or late after a control change. The bench therefore samples that flag after every single tick across the hold-off window. A wrong profile decode or word mapping appears on the lookup port as soon as the control write has settled. A reload triggered when it should not be, or left out when it should happen, is caught at once by comparing `upd_ok` just after same-value rewrites and just after changes on other channels.

// File: rtl/servo_profile_ctl.sv
module servo_profile_ctl #(
  parameter int NCH   = 8,
  parameter int NPROF = 32,
  parameter int NWORD = 8,
  parameter int DW    = 18,
  parameter int DLYW  = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(NCH)+$clog2(NPROF)+$clog2(NWORD):0] wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     cyc_tick,
  input  logic [$clog2(NCH)-1:0]   lk_ch,
  output logic [$clog2(NPROF)-1:0] lk_prof,
  output logic [31:0]              lk_ftw,
  output logic [15:0]              lk_pow,
  output logic [16:0]              lk_offs,
  output logic [2:0]               lk_adc,
  output logic [DW-1:0]            lk_a1,
  output logic [DW-1:0]            lk_b0,
  output logic [DW-1:0]            lk_b1,
  output logic [NCH-1:0]           rf_on,
  output logic [NCH-1:0]           upd_ok,
  output logic                     run_on
);
  localparam int CHW  = $clog2(NCH);
  localparam int PW   = $clog2(NPROF);
  localparam int WW   = $clog2(NWORD);
  localparam int MAW  = CHW + PW + WW;
  localparam int AW   = MAW + 1;
  localparam int MEMD = NCH * NPROF * NWORD;
  localparam int CW   = PW + 2;

  logic [DW-1:0]   mem [MEMD];
  logic [CW-1:0]   ctl [NCH];
  logic [DLYW-1:0] cnt [NCH];

  wire            is_mem = wr_en & ~wr_addr[AW-1];
  wire            is_ctl = wr_en & wr_addr[AW-1] & ~wr_addr[CHW];
  wire            is_cfg = wr_en & wr_addr[AW-1] & wr_addr[CHW];
  wire [CHW-1:0]  wch    = wr_addr[CHW-1:0];
  wire [CW-1:0]   nctl   = wr_data[CW-1:0];
  wire [MAW-1:0]  d_idx  = {wch, nctl[CW-1:2], WW'(3)};
  wire [DLYW-1:0] new_dly = mem[d_idx][8 +: DLYW];

  always_ff @(posedge clk)
    if (is_mem) mem[wr_addr[MAW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_on <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        ctl[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      if (is_cfg) run_on <= wr_data[0];
      for (int i = 0; i < NCH; i++) begin
        if (is_ctl && wch == CHW'(i) && nctl != ctl[i]) begin
          ctl[i] <= nctl;
          cnt[i] <= new_dly;
        end else if (cyc_tick && cnt[i] != '0) begin
          cnt[i] <= cnt[i] - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign rf_on[g]  = ctl[g][0];
    assign upd_ok[g] = ctl[g][0] & ctl[g][1] & (cnt[g] == '0);
  end

  wire [CHW+PW-1:0] base = {lk_ch, ctl[lk_ch][CW-1:2]};
  assign lk_prof = ctl[lk_ch][CW-1:2];
  assign lk_ftw  = {mem[{base, WW'(0)}][15:0], mem[{base, WW'(6)}][15:0]};
  assign lk_pow  = mem[{base, WW'(2)}][15:0];
  assign lk_adc  = mem[{base, WW'(3)}][2:0];
  assign lk_offs = mem[{base, WW'(4)}][16:0];
  assign lk_b1   = mem[{base, WW'(1)}];
  assign lk_a1   = mem[{base, WW'(5)}];
  assign lk_b0   = mem[{base, WW'(7)}];
endmodule

// File: rtl/servo_profile_ctl_chk.sv
module servo_profile_ctl_chk #(
  parameter int NCH = 8,
  parameter int CHW = 3,
  parameter int AW  = 12,
  parameter int DW  = 18
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic           cyc_tick,
  input logic [NCH-1:0] rf_on,
  input logic [NCH-1:0] upd_ok,
  input logic           run_on
);
  wire ctl_wr = wr_en & wr_addr[AW-1] & ~wr_addr[CHW];
  wire cfg_wr = wr_en & wr_addr[AW-1] & wr_addr[CHW];

  a_r3_rf_follows: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> rf_on[$past(wr_addr[CHW-1:0])] == $past(wr_data[0]));

  a_r5_permit_needs_rf: assert property (@(posedge clk) disable iff (rst)
    (upd_ok & ~rf_on) == '0);

  a_r6_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
    (|(upd_ok & ~$past(upd_ok))) |-> $past(cyc_tick || wr_en));

  a_r8_run_set: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> run_on == $past(wr_data[0]));

  a_r8_run_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(run_on));
endmodule

bind servo_profile_ctl servo_profile_ctl_chk #(
  .NCH(NCH), .CHW(CHW), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cyc_tick(cyc_tick), .rf_on(rf_on), .upd_ok(upd_ok), .run_on(run_on)
);

// File: tb/servo_profile_ctl_tb_top.sv
module servo_profile_ctl_tb_top;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, cyc_tick = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic [2:0]  lk_ch = '0;
  logic [4:0]  lk_prof;
  logic [31:0] lk_ftw;
  logic [15:0] lk_pow;
  logic [16:0] lk_offs;
  logic [2:0]  lk_adc;
  logic [17:0] lk_a1, lk_b0, lk_b1;
  logic [7:0]  rf_on, upd_ok;
  logic        run_on;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  servo_profile_ctl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cyc_tick(cyc_tick), .lk_ch(lk_ch), .lk_prof(lk_prof), .lk_ftw(lk_ftw),
    .lk_pow(lk_pow), .lk_offs(lk_offs), .lk_adc(lk_adc), .lk_a1(lk_a1),
    .lk_b0(lk_b0), .lk_b1(lk_b1), .rf_on(rf_on), .upd_ok(upd_ok), .run_on(run_on)
  );

  typedef struct packed {
    logic [2:0]  ch;
    logic [4:0]  prof;
    logic [31:0] ftw;
    logic [15:0] pw;
    logic [16:0] offs;
    logic [2:0]  adc;
    logic [9:0]  dly;
    logic [17:0] a1, b0, b1;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{3'd0, 5'd0,  32'h1234_5667, 16'haa55, 17'h1_f000, 3'd7, 10'd0,   18'h3f800, 18'h01000, 18'h00000},
    '{3'd1, 5'd31, 32'hdead_beef, 16'h0001, 17'h0_0123, 3'd2, 10'd5,   18'h00001, 18'h3ffff, 18'h2aaaa},
    '{3'd6, 5'd9,  32'h0000_ffff, 16'hffff, 17'h1_0000, 3'd0, 10'd1023, 18'h15555, 18'h20000, 18'h1ffff},
    '{3'd7, 5'd16, 32'hffff_0000, 16'h8000, 17'h0_ffff, 3'd5, 10'd2,   18'h12345, 18'h0abcd, 18'h00042}
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [17:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); cyc_tick = 1'b1;
    @(negedge clk); cyc_tick = 1'b0;
  endtask

  function automatic logic [11:0] pa(input int ch, input int pr, input int w);
    return 12'((ch << 8) | (pr << 3) | w);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 rf_on", 64'(rf_on), 64'h0);
    chk("R9 upd_ok", 64'(upd_ok), 64'h0);
    chk("R9 run_on", 64'(run_on), 64'h0);
    chk("R9 lk_prof", 64'(lk_prof), 64'h0);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      wr(pa(v.ch, v.prof, 0), 18'(v.ftw[31:16]));
      wr(pa(v.ch, v.prof, 1), v.b1);
      wr(pa(v.ch, v.prof, 2), 18'(v.pw));
      wr(pa(v.ch, v.prof, 3), {v.dly, 5'd0, v.adc});
      wr(pa(v.ch, v.prof, 4), 18'(v.offs));
      wr(pa(v.ch, v.prof, 5), v.a1);
      wr(pa(v.ch, v.prof, 6), 18'(v.ftw[15:0]));
      wr(pa(v.ch, v.prof, 7), v.b0);
      wr(12'h800 | 12'(v.ch), {11'd0, v.prof, 2'b01});
      lk_ch = v.ch;
      @(negedge clk);
      chk("R3 rf_on", 64'(rf_on[v.ch]), 64'h1);
      chk("R5 upd_ok en_iir off", 64'(upd_ok[v.ch]), 64'h0);
      chk("R2 prof", 64'(lk_prof), 64'(v.prof));
      chk("R1 R2 ftw", 64'(lk_ftw), 64'(v.ftw));
      chk("R2 pow", 64'(lk_pow), 64'(v.pw));
      chk("R2 offs", 64'(lk_offs), 64'(v.offs));
      chk("R2 adc", 64'(lk_adc), 64'(v.adc));
      chk("R2 a1", 64'(lk_a1), 64'(v.a1));
      chk("R2 b0", 64'(lk_b0), 64'(v.b0));
      chk("R2 b1", 64'(lk_b1), 64'(v.b1));
    end

    // channel 2: profile 4 hold-off 3, profile 5 hold-off 0
    wr(pa(2, 4, 3), {10'd3, 5'd0, 3'd1});
    wr(pa(2, 5, 3), {10'd0, 5'd0, 3'd2});
    wr(12'h802, {11'd0, 5'd4, 2'b11});
    @(negedge clk);
    chk("R3 rf immediate", 64'(rf_on[2]), 64'h1);
    chk("R6 held after change", 64'(upd_ok[2]), 64'h0);
    tick(); chk("R7 after 1 tick", 64'(upd_ok[2]), 64'h0);
    tick(); chk("R7 after 2 ticks", 64'(upd_ok[2]), 64'h0);
    tick(); chk("R6 after 3 ticks", 64'(upd_ok[2]), 64'h1);
    tick(); chk("R7 saturates", 64'(upd_ok[2]), 64'h1);
    wr(12'h802, {11'd0, 5'd4, 2'b11});
    @(negedge clk);
    chk("R4 same value no reload", 64'(upd_ok[2]), 64'h1);
    wr(12'h802, {11'd0, 5'd5, 2'b11});
    @(negedge clk);
    chk("R6 zero hold-off", 64'(upd_ok[2]), 64'h1);
    wr(12'h802, {11'd0, 5'd5, 2'b01});
    @(negedge clk);
    chk("R5 en_iir off", 64'(upd_ok[2]), 64'h0);
    chk("R5 rf stays", 64'(rf_on[2]), 64'h1);
    wr(12'h802, {11'd0, 5'd4, 2'b11});
    tick();
    wr(12'h803, {11'd0, 5'd0, 2'b11});
    @(negedge clk);
    chk("R10 other channel kept", 64'(upd_ok[2]), 64'h0);
    chk("R10 ch0 unchanged", 64'(rf_on[0]), 64'h1);
    tick(); chk("R10 count continues", 64'(upd_ok[2]), 64'h0);
    tick(); chk("R10 R6 released", 64'(upd_ok[2]), 64'h1);
    wr(12'h802, {11'd0, 5'd4, 2'b10});
    @(negedge clk);
    chk("R3 rf off", 64'(rf_on[2]), 64'h0);
    chk("R5 rf off blocks", 64'(upd_ok[2]), 64'h0);

    wr(12'h808, 18'h1);
    @(negedge clk);
    chk("R8 run set", 64'(run_on), 64'h1);
    wr(12'h800, {11'd0, 5'd0, 2'b01});
    tick();
    chk("R8 run held", 64'(run_on), 64'h1);
    wr(12'h808, 18'h2);
    @(negedge clk);
    chk("R8 run clear", 64'(run_on), 64'h0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset rf", 64'(rf_on), 64'h0);
    chk("R9 reset upd", 64'(upd_ok), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule